// File: doc/BRIEF.md
# File-Select Indirect Access Port

This block sits in front of a data register file and gives it a pointer-based access path. One address, 00h, has no storage behind it. An access to 00h is steered to the location named by a file-select pointer register. The pointer itself lives inside the block at direct address 04h, and can be read and written like any ordinary register. All other addresses pass straight through to the external register file.

For an indirect access, the block forms a 9-bit effective address. It places a bank-select bit above the 8-bit pointer. A parameter can drop the bank bit, which forces the upper address bit to zero. Two self-reference cases get special handling:

- A pointer of 00h makes an indirect read return 00h and an indirect write do nothing.
- A pointer of 04h reaches the pointer register itself, in either bank.

Reads are combinational from the current pointer value. Writes, whether to the file or to the pointer, take effect at the next rising clock edge.

Top module: `fsel_indirect_port`

## Requirements
- R1: After reset the pointer holds 00h, so a direct read of address 04h returns 00h.
- R2: A direct access to an address other than 00h and 04h drives eff_addr = {0, acc_addr}. With acc_rd high it returns file_rdata. With acc_wr high it raises file_we, and file_wdata equals acc_wdata.
- R3: A direct write to 04h loads the pointer at the next clock edge and leaves file_we low. A direct read of 04h returns the pointer value.
- R4: An access to address 00h with a pointer outside {00h, 04h} drives eff_addr = {bank_sel, pointer}. A read returns file_rdata, and a write raises file_we with the given data.
- R5: With USE_BANK = 0, bit 8 of eff_addr is 0 on every indirect access, whatever bank_sel is.
- R6: An indirect read while the pointer holds 00h returns 00h.
- R7: An indirect write while the pointer holds 00h keeps file_we low and leaves the pointer unchanged.
- R8: An indirect access while the pointer holds 04h reads or writes the pointer register itself, in either bank, and keeps file_we low.
- R9: rd_data is 00h whenever acc_rd is low.
- R10: After the pointer is incremented, the next indirect access reaches the following location. A loop that clears 20h to 2Fh through indirect writes stops when pointer bit 4 becomes set, after 16 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 8 | Direct address of the current access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| bank_sel | input | 1 | Bank-select bit used above the pointer |
| file_rdata | input | 8 | Data returned by the register file at eff_addr |
| eff_addr | output | 9 | Effective register file address |
| file_we | output | 1 | Write enable toward the register file |
| file_wdata | output | 8 | Write data toward the register file |
| rd_data | output | 8 | Read data returned to the requester |

## Verification
The properties assume that file_rdata is a combinational function of eff_addr during the same cycle. They also assume that a strobe is held stable for a whole clock period, with the pointer changing only at an edge. The bench meets both conditions:

- It drives every access at the falling edge and holds it through the next rising edge.
- Its register array answers eff_addr combinationally.

The bench never raises both strobes against the pointer address in a way that depends on ordering within one cycle.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    // Where an access finally lands after redirection
    typedef enum logic [1:0] {
        TGT_FILE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_NONE = 2'd2
    } tgt_e;

endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
    import fsel_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter bit USE_BANK = 1'b1,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1
) (
    input  logic [PTR_W-1:0] acc_addr,
    input  logic [PTR_W-1:0] ptr_q,
    input  logic             bank_sel,
    output tgt_e             tgt_kind,
    output logic [EA_W-1:0]  eff_addr
);

    localparam logic [PTR_W-1:0] PHANTOM = '0;
    localparam logic [PTR_W-1:0] PTR_LOC = PTR_W'(PTR_ADDR);

    logic             is_ind;
    logic [PTR_W-1:0] tgt_addr;
    logic             bank_bit;

    always_comb begin
        is_ind   = (acc_addr == PHANTOM);
        tgt_addr = is_ind ? ptr_q : acc_addr;
        bank_bit = bank_sel & USE_BANK;

        if (is_ind) begin
            eff_addr = {bank_bit, ptr_q};
        end else begin
            eff_addr = {1'b0, acc_addr};
        end

        // Pointer register is mirrored in every bank; the phantom slot has no storage
        if (tgt_addr == PHANTOM) begin
            tgt_kind = TGT_NONE;
        end else if (tgt_addr == PTR_LOC) begin
            tgt_kind = TGT_PTR;
        end else begin
            tgt_kind = TGT_FILE;
        end
    end

endmodule

// File: rtl/fsel_ptr_reg.sv
module fsel_ptr_reg #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] ptr_q
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ptr = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q = st_q.ptr;

endmodule

// File: rtl/fsel_indirect_port.sv
module fsel_indirect_port
    import fsel_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter bit USE_BANK = 1'b1,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] acc_addr,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [PTR_W-1:0] acc_wdata,
    input  logic             bank_sel,
    input  logic [PTR_W-1:0] file_rdata,
    output logic [EA_W-1:0]  eff_addr,
    output logic             file_we,
    output logic [PTR_W-1:0] file_wdata,
    output logic [PTR_W-1:0] rd_data
);

    tgt_e             tgt_kind;
    logic [PTR_W-1:0] ptr_q;
    logic             ptr_wr;

    fsel_decode #(
        .PTR_W    (PTR_W),
        .USE_BANK (USE_BANK),
        .PTR_ADDR (PTR_ADDR)
    ) decode_i (
        .acc_addr (acc_addr),
        .ptr_q    (ptr_q),
        .bank_sel (bank_sel),
        .tgt_kind (tgt_kind),
        .eff_addr (eff_addr)
    );

    fsel_ptr_reg #(
        .PTR_W (PTR_W)
    ) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_wr),
        .wr_data (acc_wdata),
        .ptr_q   (ptr_q)
    );

    always_comb begin
        ptr_wr     = acc_wr && (tgt_kind == TGT_PTR);
        file_we    = acc_wr && (tgt_kind == TGT_FILE);
        file_wdata = acc_wdata;
        rd_data    = '0;
        if (acc_rd) begin
            unique case (tgt_kind)
                TGT_FILE: rd_data = file_rdata;
                TGT_PTR:  rd_data = ptr_q;
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/fsel_indirect_port_chk.sv
module fsel_indirect_port_chk #(
    parameter int PTR_W    = 8,
    parameter bit USE_BANK = 1'b1,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] acc_addr,
    input logic             acc_rd,
    input logic             acc_wr,
    input logic [PTR_W-1:0] acc_wdata,
    input logic             bank_sel,
    input logic [EA_W-1:0]  eff_addr,
    input logic             file_we,
    input logic [PTR_W-1:0] rd_data,
    input logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] PTR_LOC = PTR_W'(PTR_ADDR);

    // R3
    ptr_direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == PTR_LOC) |=> (ptr_q == $past(acc_wdata)));

    // R4
    ind_addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == '0) |-> (eff_addr[PTR_W-1:0] == ptr_q));

    // R5
    no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!USE_BANK && acc_addr == '0) |-> (eff_addr[EA_W-1] == 1'b0));

    // R6
    null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == '0 && ptr_q == '0) |-> (rd_data == '0));

    // R7
    null_write_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == '0 && ptr_q == '0) |-> !file_we);

    // R7
    null_write_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !bank_sel && acc_addr == '0 && ptr_q == '0) |=> $stable(ptr_q));

    // R8
    self_ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == '0 && ptr_q == PTR_LOC) |=> (ptr_q == $past(acc_wdata)));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |-> (rd_data == '0));

endmodule

bind fsel_indirect_port fsel_indirect_port_chk #(
    .PTR_W    (PTR_W),
    .USE_BANK (USE_BANK),
    .PTR_ADDR (PTR_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .bank_sel  (bank_sel),
    .eff_addr  (eff_addr),
    .file_we   (file_we),
    .rd_data   (rd_data),
    .ptr_q     (ptr_q)
);

// File: tb/fsel_indirect_port_tb_top.sv
module fsel_indirect_port_tb_top;

    localparam int PTR_W = 8;
    localparam int EA_W  = PTR_W + 1;
    localparam int DEPTH = 1 << EA_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PTR_W-1:0] acc_addr = '0;
    logic             acc_rd = 1'b0;
    logic             acc_wr = 1'b0;
    logic [PTR_W-1:0] acc_wdata = '0;
    logic             bank_sel = 1'b0;
    logic [PTR_W-1:0] file_rdata;
    logic [EA_W-1:0]  eff_addr;
    logic             file_we;
    logic [PTR_W-1:0] file_wdata;
    logic [PTR_W-1:0] rd_data;

    logic [PTR_W-1:0] nb_rdata;
    logic [EA_W-1:0]  nb_eff;
    logic             nb_we;
    logic [PTR_W-1:0] nb_wdata;
    logic [PTR_W-1:0] nb_rd;

    logic [PTR_W-1:0] file_mem [DEPTH];
    logic [PTR_W-1:0] ref_mem  [DEPTH];

    int vectors = 0;
    int errors  = 0;
    logic [PTR_W-1:0] m_ptr = '0;
    logic [PTR_W-1:0] last_rd;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fsel_indirect_port dut_i (
        .clk, .rst_n, .acc_addr, .acc_rd, .acc_wr, .acc_wdata, .bank_sel,
        .file_rdata, .eff_addr, .file_we, .file_wdata, .rd_data
    );

    fsel_indirect_port #(.USE_BANK(1'b0)) dut_nb (
        .clk, .rst_n, .acc_addr, .acc_rd, .acc_wr, .acc_wdata, .bank_sel,
        .file_rdata(nb_rdata), .eff_addr(nb_eff), .file_we(nb_we),
        .file_wdata(nb_wdata), .rd_data(nb_rd)
    );

    assign file_rdata = file_mem[eff_addr];
    assign nb_rdata   = '0;

    always @(posedge clk) begin
        if (file_we) file_mem[eff_addr] <= file_wdata;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [PTR_W-1:0] a, input bit rd, input bit wr,
                        input logic [PTR_W-1:0] wd, input bit bk);
        bit ind;
        logic [PTR_W-1:0] tgt;
        logic [EA_W-1:0] ea;
        int kind; // 0 file, 1 pointer, 2 none
        int exp_rd;
        string tag;
        @(negedge clk);
        acc_addr = a; acc_rd = rd; acc_wr = wr; acc_wdata = wd; bank_sel = bk;
        #1;
        ind  = (a == 0);
        tgt  = ind ? m_ptr : a;
        ea   = ind ? {bk, m_ptr} : {1'b0, a};
        kind = (tgt == 0) ? 2 : (tgt == 8'h04) ? 1 : 0;
        if (ind) tag = (kind == 2) ? "R6" : (kind == 1) ? "R8" : "R4";
        else     tag = (kind == 1) ? "R3" : "R2";
        exp_rd = !rd ? 0 : (kind == 1) ? int'(m_ptr) : (kind == 0) ? int'(ref_mem[ea]) : 0;
        check(rd ? tag : "R9", int'(rd_data), exp_rd);
        check(tag, int'(eff_addr), int'(ea));
        check((kind == 2) ? "R7" : tag, int'(file_we), int'(wr && kind == 0));
        if (wr && kind == 0) check("R2", int'(file_wdata), int'(wd));
        check("R5", int'(nb_eff), ind ? int'({1'b0, m_ptr}) : int'({1'b0, a}));
        last_rd = rd_data;
        if (wr) begin
            if (kind == 1) m_ptr = wd;
            else if (kind == 0) ref_mem[ea] = wd;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        int iters;
        for (int i = 0; i < DEPTH; i++) begin
            file_mem[i] = 8'(i * 7 + 3);
            ref_mem[i]  = 8'(i * 7 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pointer reset value read back directly
        step(8'h04, 1, 0, 8'h00, 0);
        check("R1", int'(last_rd), 0);

        // R6 / R7: null pointer read and ignored write
        step(8'h00, 1, 0, 8'h00, 0);
        step(8'h00, 0, 1, 8'h5A, 0);
        step(8'h04, 1, 0, 8'h00, 0);
        check("R7", int'(last_rd), 0);

        // R2 / R4 / R10: direct loads then indirect walk
        step(8'h05, 0, 1, 8'h10, 0);
        step(8'h06, 0, 1, 8'h0A, 0);
        step(8'h04, 0, 1, 8'h05, 0);
        step(8'h00, 1, 0, 8'h00, 0);
        check("R10", int'(last_rd), 8'h10);
        step(8'h04, 0, 1, 8'h06, 0);
        step(8'h00, 1, 0, 8'h00, 0);
        check("R10", int'(last_rd), 8'h0A);

        // R4 / R5: bank bit selects upper half
        step(8'h04, 0, 1, 8'h40, 0);
        step(8'h00, 0, 1, 8'hC3, 1);
        step(8'h00, 1, 0, 8'h00, 1);
        check("R4", int'(last_rd), 8'hC3);
        step(8'h00, 1, 0, 8'h00, 0);

        // R8: indirect access to the pointer itself, both banks
        step(8'h04, 0, 1, 8'h04, 0);
        step(8'h00, 1, 0, 8'h00, 1);
        check("R8", int'(last_rd), 8'h04);
        step(8'h00, 0, 1, 8'h33, 1);
        step(8'h04, 1, 0, 8'h00, 0);
        check("R8", int'(last_rd), 8'h33);

        // R10: clear 20h..2Fh indirectly until pointer bit 4 sets
        step(8'h04, 0, 1, 8'h20, 0);
        iters = 0;
        while (1) begin
            step(8'h00, 0, 1, 8'h00, 0);
            step(8'h04, 1, 0, 8'h00, 0);
            step(8'h04, 0, 1, last_rd + 8'h01, 0);
            iters++;
            step(8'h04, 1, 0, 8'h00, 0);
            if (last_rd[4] || iters > 40) break;
        end
        check("R10", iters, 16);
        for (int i = 8'h20; i < 8'h30; i++) begin
            step(8'(i), 1, 0, 8'h00, 0);
            check("R10", int'(last_rd), 0);
        end

        // Mixed traffic over a small address set
        for (int n = 0; n < 400; n++) begin
            int pick;
            logic [PTR_W-1:0] a;
            pick = $urandom_range(0, 5);
            a = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h04 :
                8'(8'h20 + $urandom_range(0, 7));
            if (a == 8'h04 && $urandom_range(0, 1) == 1) begin
                step(a, 0, 1, 8'(($urandom_range(0, 3) == 0) ? $urandom_range(0, 8) :
                                 8'h20 + $urandom_range(0, 7)), 1'($urandom_range(0, 1)));
            end else begin
                step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
            end
        end

        step(8'h00, 0, 0, 8'h00, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule